// File: doc/BRIEF.md
# Clock-Divided Serial Master

This block is the master side of a synchronous four-wire serial link that runs in a clock-stop style. A frame starts when `start_i` is accepted while the block is idle. At that point the divide value, the word length and the transmit word are all latched. The block then pulls the active-low select line down. It generates the serial clock from the input clock, with a period of (1 + divide) input cycles. When the divide value is even, the high and low phases differ in length by one cycle.

Transmit bits leave most significant first and change on each rising serial-clock edge. Receive bits are sampled on each falling edge. The first clock fall comes one full serial period after the select line goes low. After the last rising edge, the select line stays low for one high-phase width and then rises. The completion pulse `done_o` comes in the same cycle, with the received word already in `rx_word_o`. The data output is enabled only for the span in which data bits are on the line. An external pad uses the enable to float the pin. The serial clock rests high between frames.

A controller uses the block by presenting a word, a length and a divide value, raising `start_i`, and waiting for `done_o`. If `start_i` is kept high through completion, the next frame chains on with a single idle cycle between frames.

Top module: `spi_clkdiv_master`

## Requirements
- R1: With an effective divide value d, the serial clock period is d+1 input cycles. The low phase lasts (d+1)/2 cycles, rounded down. The high phase lasts the remainder. For even d that is d/2 + 1 high and d/2 low; for odd d both phases are (d+1)/2.
- R2: A divide value of 0 behaves as 1: a period of 2 cycles, one high and one low.
- R3: In the cycle after `start_i` is accepted, `spi_ss_no` goes low. `spi_sclk_o` stays high for one full period, d+1 cycles, before its first fall.
- R4: After the rising edge that ends bit 0, the clock stays high for one high-phase width. Then `spi_ss_no` returns high. An n-bit frame keeps the select line low for exactly (n+1)(d+1) cycles.
- R5: Data leaves most significant bit first, from bit n-1 down to bit 0. `spi_dx_o` changes only together with a rising edge of `spi_sclk_o`. A receiver that samples on each falling edge collects `tx_word_i[n-1:0]`.
- R6: `spi_dr_i` is sampled at each falling edge of the serial clock. `rx_word_o` receives the n bits right-aligned, with the first-received bit at position n-1 and zeros above it. `rx_word_o` changes only in the cycle in which `done_o` is high.
- R7: `spi_dx_en_o` rises one low-phase width after `spi_ss_no` falls. It drops at the rising edge that follows bit 0. While the enable is low, `spi_dx_o` is 0.
- R8: While idle and after reset, `spi_sclk_o` and `spi_ss_no` are 1, and `spi_dx_en_o`, `busy_o` and `done_o` are 0. After reset, `rx_word_o` is 0.
- R9: A length code below 8 acts as 8 and a code above 32 acts as 32. Bits of `tx_word_i` above the active length are not sent.
- R10: `div_i`, `len_i` and `tx_word_i` are taken only when a start is accepted. Changing them during a frame has no effect on that frame.
- R11: A `start_i` raised while `busy_o` is high is ignored. It neither restarts nor extends the frame, and no extra frame follows.
- R12: `done_o` is a single-cycle pulse, and `busy_o` is low in that cycle. A `start_i` still high in the `done_o` cycle is accepted at the next edge, so the select line is high for exactly one cycle between the two frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock from which the serial clock is divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a frame; taken only while idle |
| len_i | input | LEN_W (6) | Word length in bits, clamped to MIN_W..MAX_W |
| div_i | input | DIV_W (8) | Divide value d; serial period is d+1 cycles |
| tx_word_i | input | MAX_W (32) | Word to transmit, right-aligned |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_word_o | output | MAX_W (32) | Last received word, right-aligned |
| spi_sclk_o | output | 1 | Serial clock, resting high |
| spi_ss_no | output | 1 | Active-low slave select |
| spi_dx_o | output | 1 | Serial data out |
| spi_dx_en_o | output | 1 | Output enable for the data pad; low means the pin floats |
| spi_dr_i | input | 1 | Serial data in |

## Verification
Two functions can fall in the same cycle: the completion of one frame, which latches the receive word, raises `done_o` and releases the select line, and the acceptance of the next start. The bench provokes this by holding `start_i` high across the end of a frame whose successor has different length, divide and data. It then checks three things: the select line is high for exactly one sampled cycle, the first frame's word is already present with the pulse, and the second frame keeps its own timing. A start pulsed in the middle of a frame, and inputs changed mid-frame, are judged through the same cycle-exact waveform and data comparison.

// File: rtl/csm_pkg.sv
`timescale 1ns/1ps
package csm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_LOW  = 2'd2,
      ST_HIGH = 2'd3
   } csm_state_t;

endpackage

// File: rtl/csm_phase_gen.sv
`timescale 1ns/1ps
// Derives phase lengths from the latched divide value and times each phase.
module csm_phase_gen
   import csm_pkg::*;
#(
   parameter int DIV_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [DIV_W-1:0] div_i,
   input  csm_state_t       state_i,
   output logic             phase_end_o,
   output logic             lead_mark_o
);
   localparam int CNT_W = DIV_W + 1;

   logic [DIV_W-1:0] d_eff;
   logic [CNT_W-1:0] per_d, lo_d, hi_d;
   logic [CNT_W-1:0] per_q, lo_q, hi_q;
   logic [CNT_W-1:0] cnt_q, len_sel;
   logic             active;

   // zero is treated as one so that each phase lasts at least one cycle
   assign d_eff = (div_i == '0) ? DIV_W'(1) : div_i;
   assign per_d = {1'b0, d_eff} + CNT_W'(1);
   assign lo_d  = per_d >> 1;
   assign hi_d  = per_d - lo_d;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q <= CNT_W'(2);
         lo_q  <= CNT_W'(1);
         hi_q  <= CNT_W'(1);
      end else if (load_i) begin
         per_q <= per_d;
         lo_q  <= lo_d;
         hi_q  <= hi_d;
      end
   end

   assign active = (state_i != ST_IDLE);

   always_comb begin
      unique case (state_i)
         ST_LOW:  len_sel = lo_q;
         ST_HIGH: len_sel = hi_q;
         default: len_sel = per_q;
      endcase
   end

   assign phase_end_o = active && (cnt_q == len_sel - CNT_W'(1));
   assign lead_mark_o = (state_i == ST_LEAD) && (cnt_q == lo_q - CNT_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i || phase_end_o || !active) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/csm_frame_ctl.sv
`timescale 1ns/1ps
// Frame sequencer: select, serial clock level, data enable and bit count.
module csm_frame_ctl
   import csm_pkg::*;
#(
   parameter int LEN_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [LEN_W-1:0] nbits_i,
   input  logic             phase_end_i,
   input  logic             lead_mark_i,
   output csm_state_t       state_o,
   output logic             load_o,
   output logic             sample_o,
   output logic             shift_o,
   output logic             finish_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             ss_n_o,
   output logic             sclk_o,
   output logic             dx_en_o
);
   csm_state_t       state_q;
   logic [LEN_W-1:0] bits_q;
   logic             ss_n_q, sclk_q, en_q, done_q;
   logic             last_bit, no_bits;

   assign last_bit = (bits_q == LEN_W'(1));
   assign no_bits  = (bits_q == '0);

   assign load_o   = (state_q == ST_IDLE) && start_i;
   assign sample_o = phase_end_i &&
                     ((state_q == ST_LEAD) || ((state_q == ST_HIGH) && !no_bits));
   assign shift_o  = phase_end_i && (state_q == ST_LOW) && !last_bit;
   assign finish_o = phase_end_i && (state_q == ST_HIGH) && no_bits;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         bits_q  <= '0;
         ss_n_q  <= 1'b1;
         sclk_q  <= 1'b1;
         en_q    <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_LEAD;
                  ss_n_q  <= 1'b0;
                  bits_q  <= nbits_i;
               end
            end
            ST_LEAD: begin
               if (lead_mark_i) en_q <= 1'b1;
               if (phase_end_i) begin
                  state_q <= ST_LOW;
                  sclk_q  <= 1'b0;
               end
            end
            ST_LOW: begin
               if (phase_end_i) begin
                  state_q <= ST_HIGH;
                  sclk_q  <= 1'b1;
                  bits_q  <= bits_q - LEN_W'(1);
                  if (last_bit) en_q <= 1'b0;
               end
            end
            ST_HIGH: begin
               if (phase_end_i) begin
                  if (no_bits) begin
                     state_q <= ST_IDLE;
                     ss_n_q  <= 1'b1;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_LOW;
                     sclk_q  <= 1'b0;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = done_q;
   assign ss_n_o  = ss_n_q;
   assign sclk_o  = sclk_q;
   assign dx_en_o = en_q;
endmodule

// File: rtl/csm_shifter.sv
`timescale 1ns/1ps
// Transmit and receive shift registers, MSB first.
module csm_shifter #(
   parameter int MAX_W = 32,
   parameter int LEN_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [MAX_W-1:0] tx_word_i,
   input  logic [LEN_W-1:0] nbits_i,
   input  logic             shift_i,
   input  logic             sample_i,
   input  logic             finish_i,
   input  logic             dr_i,
   output logic             dx_o,
   output logic [MAX_W-1:0] rx_word_o
);
   logic [MAX_W-1:0] tx_sr_q, rx_sr_q, rx_q;
   logic [LEN_W-1:0] sh_amt;

   // left-align so the top bit of the active word sits in the MSB
   assign sh_amt = LEN_W'(MAX_W) - nbits_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tx_sr_q <= '0;
      end else if (load_i) begin
         tx_sr_q <= tx_word_i << sh_amt;
      end else if (shift_i) begin
         tx_sr_q <= {tx_sr_q[MAX_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_sr_q <= '0;
      end else if (load_i) begin
         rx_sr_q <= '0;
      end else if (sample_i) begin
         rx_sr_q <= {rx_sr_q[MAX_W-2:0], dr_i};
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rx_q <= '0;
      end else if (finish_i) begin
         rx_q <= rx_sr_q;
      end
   end

   assign dx_o      = tx_sr_q[MAX_W-1];
   assign rx_word_o = rx_q;
endmodule

// File: rtl/spi_clkdiv_master.sv
`timescale 1ns/1ps
module spi_clkdiv_master
   import csm_pkg::*;
#(
   parameter  int MAX_W = 32,
   parameter  int MIN_W = 8,
   parameter  int DIV_W = 8,
   localparam int LEN_W = $clog2(MAX_W + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [LEN_W-1:0] len_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [MAX_W-1:0] tx_word_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [MAX_W-1:0] rx_word_o,
   output logic             spi_sclk_o,
   output logic             spi_ss_no,
   output logic             spi_dx_o,
   output logic             spi_dx_en_o,
   input  logic             spi_dr_i
);
   initial begin
      assert (MIN_W >= 2 && MIN_W <= MAX_W)
         else $fatal(1, "word length range is empty");
      assert (DIV_W >= 1 && DIV_W <= 16)
         else $fatal(1, "divide width out of range");
   end

   csm_state_t       state;
   logic [LEN_W-1:0] nbits;
   logic             load, sample, shift, finish;
   logic             phase_end, lead_mark;
   logic             dx_raw, dx_en;

   generate
      if (MIN_W == MAX_W) begin : g_fixed_len
         logic unused_len;
         assign unused_len = ^len_i;
         assign nbits      = LEN_W'(MAX_W);
      end else begin : g_clamp_len
         always_comb begin
            if (len_i < LEN_W'(MIN_W))      nbits = LEN_W'(MIN_W);
            else if (len_i > LEN_W'(MAX_W)) nbits = LEN_W'(MAX_W);
            else                            nbits = len_i;
         end
      end
   endgenerate

   csm_frame_ctl #(.LEN_W(LEN_W)) u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .nbits_i     (nbits),
      .phase_end_i (phase_end),
      .lead_mark_i (lead_mark),
      .state_o     (state),
      .load_o      (load),
      .sample_o    (sample),
      .shift_o     (shift),
      .finish_o    (finish),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .ss_n_o      (spi_ss_no),
      .sclk_o      (spi_sclk_o),
      .dx_en_o     (dx_en)
   );

   csm_phase_gen #(.DIV_W(DIV_W)) u_phase (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_i      (load),
      .div_i       (div_i),
      .state_i     (state),
      .phase_end_o (phase_end),
      .lead_mark_o (lead_mark)
   );

   csm_shifter #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_shift (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .tx_word_i (tx_word_i),
      .nbits_i   (nbits),
      .shift_i   (shift),
      .sample_i  (sample),
      .finish_i  (finish),
      .dr_i      (spi_dr_i),
      .dx_o      (dx_raw),
      .rx_word_o (rx_word_o)
   );

   assign spi_dx_en_o = dx_en;
   assign spi_dx_o    = dx_en & dx_raw;
endmodule

// File: rtl/spi_clkdiv_master_chk.sv
`timescale 1ns/1ps
module spi_clkdiv_master_chk #(
   parameter int MAX_W = 32
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             busy_o,
   input logic             done_o,
   input logic             spi_ss_no,
   input logic             spi_sclk_o,
   input logic             spi_dx_en_o,
   input logic             spi_dx_o,
   input logic [MAX_W-1:0] rx_word_o
);
   // R8
   idle_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (spi_ss_no && spi_sclk_o && !spi_dx_en_o));

   // R12
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R12
   done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o && $past(busy_o)));

   // R3
   lead_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(spi_ss_no) |-> (spi_sclk_o && !spi_dx_en_o));

   // R3
   sclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(spi_sclk_o) |-> (!spi_ss_no && $past(!spi_ss_no)));

   // R5
   dx_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spi_dx_en_o && $past(spi_dx_en_o) && (spi_dx_o != $past(spi_dx_o)))
         |-> $rose(spi_sclk_o));

   // R6
   rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_word_o != $past(rx_word_o)) |-> done_o);

   // R7
   en_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(spi_dx_en_o) |-> $rose(spi_sclk_o));
endmodule

bind spi_clkdiv_master spi_clkdiv_master_chk #(.MAX_W(MAX_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .spi_ss_no   (spi_ss_no),
   .spi_sclk_o  (spi_sclk_o),
   .spi_dx_en_o (spi_dx_en_o),
   .spi_dx_o    (spi_dx_o),
   .rx_word_o   (rx_word_o)
);

// File: tb/sim_spi_clkdiv_master.sv
`timescale 1ns/1ps
module sim_spi_clkdiv_master;
   localparam int MAX_W = 32;
   localparam int MIN_W = 8;
   localparam int DIV_W = 8;
   localparam int LEN_W = 6;

   typedef struct {
      int          t;
      int          lo;
      int          n;
      logic [31:0] tx;
      logic [31:0] slv;
      string       tg;
   } frame_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [LEN_W-1:0] len = 6'd8;
   logic [DIV_W-1:0] div = '0;
   logic [MAX_W-1:0] tx = '0;
   logic             busy, done, sclk, ss_n, dx, dx_en;
   logic [MAX_W-1:0] rx;
   logic             dr = 1'b0;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   bit mon_on = 1'b0;

   frame_t exp_q[$];

   always #2.5 clk = ~clk;

   spi_clkdiv_master #(.MAX_W(MAX_W), .MIN_W(MIN_W), .DIV_W(DIV_W)) u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .len_i       (len),
      .div_i       (div),
      .tx_word_i   (tx),
      .busy_o      (busy),
      .done_o      (done),
      .rx_word_o   (rx),
      .spi_sclk_o  (sclk),
      .spi_ss_no   (ss_n),
      .spi_dx_o    (dx),
      .spi_dx_en_o (dx_en),
      .spi_dr_i    (dr)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act,
                      input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", what, act, expv);
      end
   endtask

   function automatic logic [31:0] mask_n(input int n);
      if (n >= 32) return 32'hFFFF_FFFF;
      return (32'h1 << n) - 32'h1;
   endfunction

   // expected item from the requirements: R1 R2 R9
   function automatic frame_t mk(input int d, input int l, input logic [31:0] t,
                                 input logic [31:0] s, input string tg);
      frame_t f;
      int de;
      de = (d == 0) ? 1 : d;
      f.t  = de + 1;
      f.lo = (de % 2 == 0) ? de / 2 : (de + 1) / 2;
      f.n  = (l < 8) ? 8 : ((l > 32) ? 32 : l);
      f.tx = t;
      f.slv = s;
      f.tg = tg;
      return f;
   endfunction

   // ---------------- monitor and slave model ----------------
   bit          inf = 1'b0;
   int          k;
   frame_t      cur;
   logic [31:0] cap, rx_prev;
   int          sidx;
   logic        prev_sclk;
   int          e_wave, e_en, e_ctl, e_hold, e_idle;

   always @(negedge clk) begin
      if (mon_on) begin
         if (!inf) begin
            if (ss_n === 1'b0) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R11 unexpected frame start", 32'd1, 32'd0);
               end else begin
                  cur = exp_q.pop_front();
                  inf = 1'b1;
                  k = 0;
                  cap = '0;
                  sidx = cur.n - 1;
                  dr = cur.slv[sidx];
                  rx_prev = rx;
                  e_wave = 0; e_en = 0; e_ctl = 0; e_hold = 0;
               end
            end else if (!(sclk === 1'b1 && dx_en === 1'b0 && busy === 1'b0 &&
                           done === 1'b0 && dx === 1'b0)) begin
               e_idle++;
            end
         end
         if (inf) begin
            if (k < (cur.n + 1) * cur.t) begin
               logic es, ee;
               es = (k < cur.t) ? 1'b1 : (((k - cur.t) % cur.t) < cur.lo ? 1'b0 : 1'b1);
               ee = (k >= cur.lo) && (k < cur.n * cur.t + cur.lo);
               if (ss_n !== 1'b0 || sclk !== es) e_wave++;
               if (dx_en !== ee || (!dx_en && dx !== 1'b0)) e_en++;
               if (busy !== 1'b1 || done !== 1'b0) e_ctl++;
               if (rx !== rx_prev) e_hold++;
               if (k > 0 && prev_sclk === 1'b1 && sclk === 1'b0) cap = {cap[30:0], dx};
               if (k > 0 && prev_sclk === 1'b0 && sclk === 1'b1) begin
                  sidx--;
                  if (sidx >= 0) dr = cur.slv[sidx];
               end
            end else begin
               // R1 R3 R4: clock and select waveform cycle by cycle
               chk(e_wave == 0, {cur.tg, " sclk/select waveform mismatches"}, e_wave, 0);
               // R7: data enable window and idle data level
               chk(e_en == 0, {cur.tg, " R7 data enable window mismatches"}, e_en, 0);
               // R12: busy high and done low throughout the frame
               chk(e_ctl == 0, {cur.tg, " R12 busy/done inside frame"}, e_ctl, 0);
               // R6: received word held until completion
               chk(e_hold == 0, {cur.tg, " R6 rx word changed mid-frame"}, e_hold, 0);
               // R4 R12: select released together with the done pulse
               chk(ss_n === 1'b1 && done === 1'b1 && busy === 1'b0,
                   {cur.tg, " R4 end of frame {ss_n,done,busy}"},
                   {29'd0, ss_n, done, busy}, 32'd6);
               // R6: received word right-aligned, upper bits zero
               chk(rx === (cur.slv & mask_n(cur.n)), {cur.tg, " R6 received word"},
                   rx, cur.slv & mask_n(cur.n));
               // R5 R9: bits seen by the slave, MSB first, only active length
               chk(cap === (cur.tx & mask_n(cur.n)), {cur.tg, " R5 slave-captured word"},
                   cap, cur.tx & mask_n(cur.n));
               inf = 1'b0;
            end
            prev_sclk = sclk;
            k++;
         end
      end
   end

   // ---------------- driver ----------------
   task automatic wait_idle();
      do @(posedge clk); while (inf || exp_q.size() != 0);
      @(negedge clk);
   endtask

   // mode 0 plain, 1 change inputs mid-frame (R10), 2 start pulse mid-frame (R11)
   task automatic send(input int d, input int l, input logic [31:0] t,
                       input logic [31:0] s, input int mode, input string tg);
      wait_idle();
      exp_q.push_back(mk(d, l, t, s, tg));
      div = DIV_W'(d);
      len = LEN_W'(l);
      tx = t;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      if (mode == 1) begin
         div = DIV_W'(d + 5);
         len = LEN_W'(l + 7);
         tx = ~t;
      end else if (mode == 2) begin
         tx = ~t;
         div = DIV_W'(1);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait_idle();
      if (mode == 2) begin
         repeat (6) @(negedge clk);
         // R11: no extra frame follows the ignored request
         chk(busy === 1'b0 && ss_n === 1'b1, "R11 idle after ignored start",
             {30'd0, busy, ss_n}, 32'd1);
      end
   endtask

   task automatic chain();
      wait_idle();
      exp_q.push_back(mk(3, 9, 32'h0000_0155, 32'h0000_00AA, "R12 chain-a"));
      div = 8'd3; len = 6'd9; tx = 32'h0000_0155;
      start = 1'b1;
      do @(negedge clk); while (busy !== 1'b1);
      exp_q.push_back(mk(2, 12, 32'h0000_0C3A, 32'h0000_05E1, "R12 chain-b"));
      div = 8'd2; len = 6'd12; tx = 32'h0000_0C3A;
      do @(negedge clk); while (done !== 1'b1);
      @(negedge clk);
      // R12: start present in the done cycle is accepted at the next edge
      chk(ss_n === 1'b0 && busy === 1'b1, "R12 chained frame accepted",
          {30'd0, ss_n, busy}, 32'd1);
      start = 1'b0;
      wait_idle();
   endtask

   initial begin
      e_idle = 0;
      repeat (3) @(negedge clk);
      // R8: reset state
      chk(ss_n === 1'b1 && sclk === 1'b1 && dx_en === 1'b0 && busy === 1'b0 &&
          done === 1'b0 && rx === '0, "R8 reset state",
          {26'd0, ss_n, sclk, dx_en, busy, done, |rx}, 32'h30);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      send(1, 8,  32'h0000_00A5, 32'h0000_003C, 0, "R1 d1");
      send(2, 8,  32'h0000_0096, 32'h0000_00E7, 0, "R1 d2");
      send(3, 16, 32'h0000_B00F, 32'h0000_4D21, 0, "R1 d3");
      send(4, 12, 32'h0000_0ACE, 32'h0000_0531, 0, "R1 d4");
      send(0, 8,  32'h0000_0071, 32'h0000_00C2, 0, "R2 d0");
      send(7, 32, 32'hDEAD_BEEF, 32'h1234_5678, 0, "R1 d7");
      send(6, 40, 32'h8000_0001, 32'hF0F0_1234, 0, "R9 long");
      send(5, 4,  32'hFFFF_FF5A, 32'hFFFF_FFB3, 0, "R9 short");
      send(3, 10, 32'h0000_02D3, 32'h0000_016E, 1, "R10 inputs");
      send(2, 14, 32'h0000_2B6D, 32'h0000_1C07, 2, "R11 start");
      chain();
      send(8, 8,  32'h0000_0080, 32'h0000_0001, 0, "R1 d8");
      repeat (4) @(negedge clk);
      // R8: idle levels between frames
      chk(e_idle == 0, "R8 idle line levels", e_idle, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule